// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block gives a host access to a fixed set of general-purpose pins through a memory-mapped register port. Each pin owns a 4 KiB window that holds three 32-bit registers. The first register drives an output level and reads back the synchronized input. The second configures event detection. The third holds a sticky pending flag. The host reads and writes these registers over a simple single-cycle bus. Read data comes back registered one clock after the request.

Each input passes through a two-flop synchronizer. The block then watches the input for a level or an edge, chosen per pin. When the selected event occurs and latching is enabled, the pin's pending flag is set. The flag stays set until software writes it back as zero. Every pin whose flag is pending, whose interrupt is enabled and which is routed to the host target contributes to a single registered interrupt line.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads zero, `pin_out` is all zero, `host_irq` is low and `bus_rdata` is zero.
- R2: Pin p's registers sit at byte address p*0x1000 plus the register offset: output/input register at 0x4, configuration at 0x8, status at 0xC. A write to one pin leaves the other pins' registers unchanged.
- R3: In the output/input register, bit 1 is writable, reads back, and drives `pin_out[p]` from the clock edge that takes the write. Bit 0 is read-only and shows the input after two synchronizer flops. All other bits read zero.
- R4: The configuration register holds eight writable bits that read back, and its upper bits read zero. Bit 0 is the interrupt enable, bit 1 the polarity, bits [3:2] the detection mode, bit 4 the latch enable, and bits [7:5] the target, where value 3 selects the host.
- R5: Detection mode 0 is level: the event is active while the synchronized input equals the polarity bit (1 = high active, 0 = low active). Mode 1 detects a rising edge, mode 2 a falling edge and mode 3 either edge. The edge modes ignore polarity. The status register can be read as set once three clock edges have passed after an input change.
- R6: Status bit 0 is set only while latch enable (configuration bit 4) is 1. It is cleared by writing the status register with bit 0 = 0. Writing bit 0 = 1 has no effect.
- R7: In level mode, the event sets the status on every cycle that the active level lasts. A clear write during that time leaves the status set.
- R8: If a clear write and a detected event fall on the same clock edge, the status ends up set.
- R9: `host_irq` is the registered OR over all pins of (status AND enable AND target == 3). It rises one clock after the status it reflects.
- R10: Reads of offsets other than 0x4/0x8/0xC, and reads of pin windows at or above the pin count, return zero. Writes to such addresses change no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; data is returned on the next cycle |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Asynchronous pin input levels |
| pin_out | output | NUM_PINS | Output levels driven onto the pins |
| host_irq | output | 1 | Registered interrupt request to the host |

## Verification
A wrong pending flag becomes visible at the ports in two ways. It can be read through the status register one clock after the read strobe, and it shows on `host_irq` one clock after the flag changes. A wrong synchronizer or edge history shows up as the status being set too early, too late, or for the wrong edge. The bench therefore reads status at fixed cycle counts after each input change. The event-versus-clear race is driven to the exact edge where both meet, so a priority error shows in the very next read.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int WIN_BITS = 12;
  localparam logic [WIN_BITS-1:0] OFS_IO  = 12'h004;
  localparam logic [WIN_BITS-1:0] OFS_CFG = 12'h008;
  localparam logic [WIN_BITS-1:0] OFS_ST  = 12'h00C;

  localparam int CFG_W    = 8;
  localparam int B_EN     = 0;
  localparam int B_POL    = 1;
  localparam int B_MODE   = 2;
  localparam int B_RAW    = 4;
  localparam int B_TGT    = 5;
  localparam logic [2:0] TGT_HOST = 3'd3;

  typedef enum logic [1:0] {
    DET_LEVEL = 2'd0,
    DET_RISE  = 2'd1,
    DET_FALL  = 2'd2,
    DET_BOTH  = 2'd3
  } det_mode_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sin,
  input  logic             wr_io,
  input  logic             wr_cfg,
  input  logic             wr_st,
  input  logic [CFG_W-1:0] wdata,
  output logic             out_q,
  output logic [CFG_W-1:0] cfg_q,
  output logic             st_q,
  output logic             irq_req
);
  logic      prev;
  logic      evt;
  det_mode_e mode;

  assign mode = det_mode_e'(cfg_q[B_MODE +: 2]);

  always_comb begin
    unique case (mode)
      DET_LEVEL: evt = (sin == cfg_q[B_POL]);
      DET_RISE:  evt = sin & ~prev;
      DET_FALL:  evt = ~sin & prev;
      default:   evt = sin ^ prev;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= 1'b0;
      out_q <= 1'b0;
      cfg_q <= '0;
      st_q  <= 1'b0;
    end else begin
      prev <= sin;
      if (wr_io)  out_q <= wdata[1];
      if (wr_cfg) cfg_q <= wdata;
      if (cfg_q[B_RAW] && evt)       st_q <= 1'b1;
      else if (wr_st && !wdata[0])   st_q <= 1'b0;
    end
  end

  assign irq_req = st_q & cfg_q[B_EN] & (cfg_q[B_TGT +: 3] == TGT_HOST);

  a_r6_set_needs_latch: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q) |-> $past(cfg_q[B_RAW]));
  a_r8_event_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[B_RAW] && evt && wr_st) |=> st_q);
  a_r3_out_holds: assert property (@(posedge clk) disable iff (rst)
    !wr_io |=> $stable(out_q));
  a_r5_rise_latches: assert property (@(posedge clk) disable iff (rst)
    (mode == DET_RISE && cfg_q[B_RAW] && !wr_cfg && $rose(sin)) |=> st_q);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [31:0]         bus_wdata,
  input  logic                bus_rd,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic                host_irq
);
  localparam int IDX_W = ADDR_W - WIN_BITS;

  logic [IDX_W-1:0]    idx;
  logic [WIN_BITS-1:0] ofs;
  logic                pin_ok;
  logic [NUM_PINS-1:0] sin_v, out_v, st_v, req_v;
  logic [NUM_PINS-1:0] wr_io_v, wr_cfg_v, wr_st_v;
  logic [CFG_W-1:0]    cfg_a [NUM_PINS];
  logic [31:0]         rd_mux;
  logic                unused_wdata_hi;

  assign idx    = bus_addr[ADDR_W-1:WIN_BITS];
  assign ofs    = bus_addr[WIN_BITS-1:0];
  assign pin_ok = (32'(idx) < NUM_PINS);
  assign unused_wdata_hi = ^bus_wdata[31:CFG_W];

  gpio_sync #(.W(NUM_PINS), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(sin_v)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic sel;
    assign sel         = bus_wr && pin_ok && (idx == IDX_W'(p));
    assign wr_io_v[p]  = sel && (ofs == OFS_IO);
    assign wr_cfg_v[p] = sel && (ofs == OFS_CFG);
    assign wr_st_v[p]  = sel && (ofs == OFS_ST);

    gpio_pin_cell u_cell (
      .clk(clk), .rst(rst), .sin(sin_v[p]),
      .wr_io(wr_io_v[p]), .wr_cfg(wr_cfg_v[p]), .wr_st(wr_st_v[p]),
      .wdata(bus_wdata[CFG_W-1:0]),
      .out_q(out_v[p]), .cfg_q(cfg_a[p]), .st_q(st_v[p]), .irq_req(req_v[p])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (pin_ok && idx == IDX_W'(p)) begin
        case (ofs)
          OFS_IO:  rd_mux = {30'b0, out_v[p], sin_v[p]};
          OFS_CFG: rd_mux = {{(32-CFG_W){1'b0}}, cfg_a[p]};
          OFS_ST:  rd_mux = {31'b0, st_v[p]};
          default: rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      host_irq  <= 1'b0;
    end else begin
      bus_rdata <= bus_rd ? rd_mux : '0;
      host_irq  <= |req_v;
    end
  end

  assign pin_out = out_v;

  a_r9_irq_follows_request: assert property (@(posedge clk) disable iff (rst)
    host_irq == $past(|req_v));
  a_r10_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !pin_ok) |=> bus_rdata == 32'd0);
  a_r10_unmapped_write_no_strobe: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !pin_ok) |-> (wr_io_v == '0 && wr_cfg_v == '0 && wr_st_v == '0));
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_io_v, wr_cfg_v, wr_st_v}));
endmodule

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;
  localparam int NP = 8;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic          host_irq;

  gpio_irq_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .host_irq(host_irq)
  );

  always #2 clk = ~clk;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic rd_d = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] adr(int pin, int ofs);
    return AW'(pin * 4096 + ofs);
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int pin, int ofs, logic [31:0] d);
    bus_addr = adr(pin, ofs); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int pin, int ofs, logic [31:0] exp, string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    bus_addr = adr(pin, ofs); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  always @(posedge clk) rd_d <= bus_rd;

  always @(negedge clk) begin
    if (rd_d) begin
      if (sb_q.size() == 0) check("scoreboard underflow", 32'd1, 32'd0);
      else begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, bus_rdata, it.exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    check("R1 pin_out", 32'(pin_out), 32'd0);
    check("R1 host_irq", 32'(host_irq), 32'd0);
    check("R1 rdata", bus_rdata, 32'd0);
    rd(0, 8, 0, "R1 cfg0");
    rd(3, 12, 0, "R1 status3");
    // R4 config readback, R2 window separation
    wr(2, 8, 32'hFFFF_FFFF);
    rd(2, 8, 32'h0000_00FF, "R4 cfg upper bits zero");
    wr(5, 8, 32'h42);
    rd(5, 8, 32'h42, "R2 pin5 cfg");
    rd(4, 8, 32'h0, "R2 pin4 untouched");
    wr(2, 8, 0);
    // R3 output and input
    wr(0, 4, 32'h2);
    check("R3 pin_out set", 32'(pin_out), 32'h01);
    pin_in[0] = 1'b1;
    idle(3);
    rd(0, 4, 32'h3, "R3 io readback");
    wr(0, 4, 32'hFFFF_FFFD);
    check("R3 pin_out clear", 32'(pin_out), 32'h00);
    rd(0, 4, 32'h1, "R3 input only");
    // R10 unmapped accesses
    wr(9, 4, 32'h2);
    wr(8, 8, 32'hFF);
    wr(0, 0, 32'hFFFF_FFFF);
    wr(0, 16, 32'hFFFF_FFFF);
    check("R10 pin_out unchanged", 32'(pin_out), 32'h00);
    rd(9, 4, 0, "R10 pin9 read");
    rd(8, 8, 0, "R10 pin8 read");
    rd(0, 0, 0, "R10 offset 0");
    rd(0, 16, 0, "R10 offset 0x10");
    rd(0, 8, 0, "R10 pin0 cfg unchanged");
    rd(0, 4, 32'h1, "R10 pin0 io unchanged");
    // R5/R7 level active high on pin 1
    wr(1, 8, 32'h73);
    pin_in[1] = 1'b1;
    idle(4);
    rd(1, 12, 1, "R5 level high");
    idle(1);
    check("R9 irq level", 32'(host_irq), 32'd1);
    wr(1, 12, 0);
    rd(1, 12, 1, "R7 clear blocked by level");
    pin_in[1] = 1'b0;
    idle(3);
    wr(1, 12, 0);
    rd(1, 12, 0, "R6 clear");
    idle(1);
    check("R9 irq drops", 32'(host_irq), 32'd0);
    // R5 level active low
    wr(1, 8, 32'h71);
    idle(2);
    rd(1, 12, 1, "R5 level low");
    pin_in[1] = 1'b1;
    idle(3);
    wr(1, 12, 0);
    rd(1, 12, 0, "R6 clear after low");
    wr(1, 8, 0);
    // R5 rising on pin 3
    wr(3, 8, 32'h75);
    pin_in[3] = 1'b1;
    idle(3);
    rd(3, 12, 1, "R5 rising");
    wr(3, 12, 0);
    rd(3, 12, 0, "R6 clear edge");
    pin_in[3] = 1'b0;
    idle(4);
    rd(3, 12, 0, "R5 rising ignores fall");
    wr(3, 12, 1);
    rd(3, 12, 0, "R6 write one no set");
    // R5 falling
    wr(3, 8, 32'h79);
    pin_in[3] = 1'b1;
    idle(4);
    rd(3, 12, 0, "R5 falling ignores rise");
    pin_in[3] = 1'b0;
    idle(4);
    rd(3, 12, 1, "R5 falling");
    wr(3, 12, 0);
    // R5 both
    wr(3, 8, 32'h7D);
    pin_in[3] = 1'b1;
    idle(4);
    rd(3, 12, 1, "R5 both rise");
    wr(3, 12, 0);
    pin_in[3] = 1'b0;
    idle(4);
    rd(3, 12, 1, "R5 both fall");
    wr(3, 12, 0);
    // R6 latch disabled
    wr(3, 8, 32'h6D);
    pin_in[3] = 1'b1;
    idle(4);
    pin_in[3] = 1'b0;
    idle(4);
    rd(3, 12, 0, "R6 latch disabled");
    // R9 target and enable gating
    wr(3, 8, 32'h1D);
    pin_in[3] = 1'b1;
    idle(5);
    rd(3, 12, 1, "R9 status with target 0");
    check("R9 irq target 0", 32'(host_irq), 32'd0);
    wr(3, 8, 32'h7D);
    idle(2);
    check("R9 irq target 3", 32'(host_irq), 32'd1);
    wr(3, 8, 32'h7C);
    idle(2);
    check("R9 irq disabled", 32'(host_irq), 32'd0);
    rd(3, 12, 1, "R9 status kept when disabled");
    wr(3, 12, 0);
    pin_in[3] = 1'b0;
    // R8 event and clear on the same edge
    wr(3, 8, 32'h75);
    idle(4);
    pin_in[3] = 1'b1;
    idle(2);
    wr(3, 12, 0);
    rd(3, 12, 1, "R8 event wins");
    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule